// File: doc/BRIEF.md
# Shared Atomic Conditional-Update Word Store

A small register-based word memory that several requester ports share. Each port can issue plain reads and plain writes. It can also issue conditional updates: the store reads one or two words, compares them with the values the requester expects, and replaces them only when every comparison holds. Each conditional update runs as one indivisible step with respect to all ports. A round-robin arbiter picks one requester. The chosen operation reads, compares and writes inside a single execute cycle. No other port is accepted until that cycle ends.

Four conditional forms exist. The first compares and replaces one word. The second treats an aligned even/odd pair of words as one double-width location. The third names two independent words with separate expected values and updates both or neither. The fourth compares a single word but, on a match, writes both that word and its odd neighbour. Every response carries a success flag, an error flag and the contents the words held before the operation. The values written are never returned.

Top module: `atomic_cas_mem`

## Requirements
- R1: After reset every word reads as zero, no response is valid, and no port is ready while no port is requesting.
- R2: Opcode 0 reads word addr_a and returns it in old_a with ok=1. Opcode 1 writes new_a to addr_a, always reports ok=1, and returns the prior contents in old_a.
- R3: Opcode 2 compares word addr_a with cmp_a. On equality it writes new_a and reports ok=1. Otherwise it leaves memory unchanged and reports ok=0. In both cases old_a returns the prior contents.
- R4: Opcode 3 treats words addr_a (even) and addr_a+1 as one location. It compares them with cmp_a and cmp_b. Both words take new_a and new_b only if both match, otherwise neither changes. old_a and old_b return the prior pair.
- R5: Opcode 4 compares word addr_a with cmp_a and word addr_b with cmp_b. Both are written only when both match. When addr_a equals addr_b, new_b is the value that remains.
- R6: Opcode 5 compares only word addr_a (even) with cmp_a. On a match it writes new_a to addr_a and new_b to addr_a+1, whatever addr_a+1 held. old_b returns the prior addr_a+1 contents.
- R7: Opcode 3 or 5 with an odd addr_a, and opcodes 6 and 7, report err=1 and ok=0 with old values of zero, and change no memory.
- R8: Only requesting ports are granted. Among simultaneous requesters, the grant goes to the first requesting port after the most recently granted one, in rising order with wrap-around (port 0 first after reset).
- R9: At most one request is accepted per cycle. No request is accepted in the cycle after an acceptance. The requesting port's rsp_valid pulses for one cycle, two clock edges after the accepting edge, and responses to one port keep request order.
- R10: When several ports update the same word in one batch, they take effect one after another in grant order. Each later comparison sees the earlier result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NP | Request valid per port |
| req_ready | output | NP | Request accepted this edge per port |
| req_op | input | NP x 3 | Opcode per port |
| req_addr_a | input | NP x AW | First word address |
| req_addr_b | input | NP x AW | Second word address (opcode 4) |
| req_cmp_a | input | NP x DW | Expected value, first word |
| req_cmp_b | input | NP x DW | Expected value, second word |
| req_new_a | input | NP x DW | Replacement value, first word |
| req_new_b | input | NP x DW | Replacement value, second word |
| rsp_valid | output | NP | One-cycle response pulse per port |
| rsp_ok | output | NP | Substitution or access succeeded |
| rsp_err | output | NP | Illegal alignment or opcode |
| rsp_old_a | output | NP x DW | Prior contents of the first word |
| rsp_old_b | output | NP x DW | Prior contents of the second word (zero for single-word ops) |

## Verification
Every conditional form is run twice, once with matching expected values and once with a mismatch on each compared word. The matching run shows that a write happens. The mismatch run shows that a partial match writes nothing, and a later read at the ports confirms it. The compare-one-write-two form is given a deliberately wrong cmp_b. This separates it from the double-wide form, which must fail on that input. Batches of simultaneous requests, including four ports racing for one word, show the rotation order and the serialisation of conditional updates. The error inputs (odd pair addresses, unused opcodes) are each followed by reads that show memory untouched.

// File: rtl/acm_pkg.sv
package acm_pkg;
   localparam logic [2:0] OP_RD   = 3'd0;
   localparam logic [2:0] OP_WR   = 3'd1;
   localparam logic [2:0] OP_CAS  = 3'd2;
   localparam logic [2:0] OP_CASW = 3'd3;
   localparam logic [2:0] OP_CAS2 = 3'd4;
   localparam logic [2:0] OP_CSWP = 3'd5;
endpackage

// File: rtl/acm_rr_arb.sv
module acm_rr_arb #(
   parameter int N  = 4,
   parameter int PW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          en,
   output logic [N-1:0]  gnt,
   output logic [PW-1:0] gidx
);
   logic [PW-1:0] ptr_q;
   logic          found;

   always_comb begin
      gnt   = '0;
      gidx  = '0;
      found = 1'b0;
      for (int k = 0; k < N; k++) begin
         int j;
         j = int'(ptr_q) + k;
         if (j >= N) j = j - N;
         if (!found && en && req[j]) begin
            found  = 1'b1;
            gnt[j] = 1'b1;
            gidx   = PW'(j);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (found)
         ptr_q <= (int'(gidx) == N - 1) ? '0 : gidx + 1'b1;
   end
endmodule

// File: rtl/acm_word_store.sv
module acm_word_store #(
   parameter int DW    = 16,
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra_a,
   input  logic [AW-1:0] ra_b,
   output logic [DW-1:0] rd_a,
   output logic [DW-1:0] rd_b,
   input  logic          we_a,
   input  logic [AW-1:0] wa_a,
   input  logic [DW-1:0] wd_a,
   input  logic          we_b,
   input  logic [AW-1:0] wa_b,
   input  logic [DW-1:0] wd_b
);
   logic [DW-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DW-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (we_b && wa_b == AW'(i))
            word_q <= wd_b;
         else if (we_a && wa_a == AW'(i))
            word_q <= wd_a;
      end
      assign words[i] = word_q;
   end

   assign rd_a = words[ra_a];
   assign rd_b = words[ra_b];
endmodule

// File: rtl/acm_exec.sv
module acm_exec
   import acm_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 4
) (
   input  logic [2:0]    op,
   input  logic [AW-1:0] addr_a,
   input  logic [AW-1:0] addr_b,
   input  logic [DW-1:0] cmp_a,
   input  logic [DW-1:0] cmp_b,
   input  logic [DW-1:0] rd_a,
   input  logic [DW-1:0] rd_b,
   output logic [AW-1:0] sel_b,
   output logic          we_a,
   output logic          we_b,
   output logic          ok,
   output logic          err,
   output logic [DW-1:0] old_a,
   output logic [DW-1:0] old_b
);
   logic ma, mb;

   assign sel_b = (op == OP_CAS2) ? addr_b : {addr_a[AW-1:1], 1'b1};
   assign ma    = (rd_a == cmp_a);
   assign mb    = (rd_b == cmp_b);

   always_comb begin
      ok    = 1'b0;
      err   = 1'b0;
      we_a  = 1'b0;
      we_b  = 1'b0;
      old_a = rd_a;
      old_b = '0;
      case (op)
         OP_RD:  ok = 1'b1;
         OP_WR: begin
            ok   = 1'b1;
            we_a = 1'b1;
         end
         OP_CAS: begin
            ok   = ma;
            we_a = ma;
         end
         OP_CASW, OP_CSWP: begin
            if (addr_a[0]) begin
               err = 1'b1;
            end else begin
               ok   = (op == OP_CASW) ? (ma && mb) : ma;
               we_a = ok;
               we_b = ok;
            end
            old_b = rd_b;
         end
         OP_CAS2: begin
            ok    = ma && mb;
            we_a  = ok;
            we_b  = ok;
            old_b = rd_b;
         end
         default: err = 1'b1;
      endcase
      if (err) begin
         old_a = '0;
         old_b = '0;
      end
   end
endmodule

// File: rtl/atomic_cas_mem.sv
module atomic_cas_mem #(
   parameter int NP    = 4,
   parameter int DW    = 16,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = (NP > 1) ? $clog2(NP) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NP-1:0]          req_valid,
   output logic [NP-1:0]          req_ready,
   input  logic [NP-1:0][2:0]     req_op,
   input  logic [NP-1:0][AW-1:0]  req_addr_a,
   input  logic [NP-1:0][AW-1:0]  req_addr_b,
   input  logic [NP-1:0][DW-1:0]  req_cmp_a,
   input  logic [NP-1:0][DW-1:0]  req_cmp_b,
   input  logic [NP-1:0][DW-1:0]  req_new_a,
   input  logic [NP-1:0][DW-1:0]  req_new_b,
   output logic [NP-1:0]          rsp_valid,
   output logic [NP-1:0]          rsp_ok,
   output logic [NP-1:0]          rsp_err,
   output logic [NP-1:0][DW-1:0]  rsp_old_a,
   output logic [NP-1:0][DW-1:0]  rsp_old_b
);
   if (NP < 2) begin : g_np_chk
      $error("atomic_cas_mem: NP must be at least 2");
   end
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_depth_chk
      $error("atomic_cas_mem: DEPTH must be a power of two of at least 2");
   end

   logic                busy_q;
   logic [NP-1:0]       gnt;
   logic [PW-1:0]       gidx;
   logic [PW-1:0]       cur_port;
   logic [2:0]          cur_op;
   logic [AW-1:0]       cur_a, cur_b, sel_b;
   logic [DW-1:0]       cur_ca, cur_cb, cur_na, cur_nb;
   logic [DW-1:0]       rd_a, rd_b, old_a, old_b;
   logic                we_a, we_b, x_ok, x_err;

   acm_rr_arb #(.N(NP), .PW(PW)) arb_i (
      .clk(clk), .rst_n(rst_n), .req(req_valid), .en(!busy_q),
      .gnt(gnt), .gidx(gidx)
   );
   assign req_ready = gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         cur_port <= '0;
         cur_op   <= '0;
         cur_a    <= '0;
         cur_b    <= '0;
         cur_ca   <= '0;
         cur_cb   <= '0;
         cur_na   <= '0;
         cur_nb   <= '0;
      end else if (busy_q) begin
         busy_q <= 1'b0;
      end else if (|gnt) begin
         busy_q   <= 1'b1;
         cur_port <= gidx;
         cur_op   <= req_op[gidx];
         cur_a    <= req_addr_a[gidx];
         cur_b    <= req_addr_b[gidx];
         cur_ca   <= req_cmp_a[gidx];
         cur_cb   <= req_cmp_b[gidx];
         cur_na   <= req_new_a[gidx];
         cur_nb   <= req_new_b[gidx];
      end
   end

   acm_exec #(.DW(DW), .AW(AW)) exec_i (
      .op(cur_op), .addr_a(cur_a), .addr_b(cur_b),
      .cmp_a(cur_ca), .cmp_b(cur_cb), .rd_a(rd_a), .rd_b(rd_b),
      .sel_b(sel_b), .we_a(we_a), .we_b(we_b), .ok(x_ok), .err(x_err),
      .old_a(old_a), .old_b(old_b)
   );

   acm_word_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) store_i (
      .clk(clk), .rst_n(rst_n),
      .ra_a(cur_a), .ra_b(sel_b), .rd_a(rd_a), .rd_b(rd_b),
      .we_a(busy_q && we_a), .wa_a(cur_a), .wd_a(cur_na),
      .we_b(busy_q && we_b), .wa_b(sel_b), .wd_b(cur_nb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= '0;
         rsp_ok    <= '0;
         rsp_err   <= '0;
         rsp_old_a <= '0;
         rsp_old_b <= '0;
      end else begin
         rsp_valid <= '0;
         if (busy_q) begin
            rsp_valid[cur_port] <= 1'b1;
            rsp_ok[cur_port]    <= x_ok;
            rsp_err[cur_port]   <= x_err;
            rsp_old_a[cur_port] <= old_a;
            rsp_old_b[cur_port] <= old_b;
         end
      end
   end
endmodule

// File: rtl/acm_chk.sv
module acm_chk #(
   parameter int NP = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NP-1:0] req_valid,
   input logic [NP-1:0] req_ready,
   input logic [NP-1:0] rsp_valid,
   input logic [NP-1:0] rsp_ok,
   input logic [NP-1:0] rsp_err
);
   AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_valid & req_ready)); // R9
   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready & ~req_valid) == '0); // R8
   AST_HOLD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (|(req_valid & req_ready)) |=> (req_ready == '0)); // R9
   AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_valid)); // R9

   for (genvar i = 0; i < NP; i++) begin : g_port
      AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[i] && req_ready[i]) |-> ##2 rsp_valid[i]); // R9
      AST_ERR_NOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid[i] && rsp_err[i]) |-> !rsp_ok[i]); // R7
   end
endmodule

bind atomic_cas_mem acm_chk #(.NP(NP)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err)
);

// File: tb/atomic_cas_mem_tb_top.sv
module atomic_cas_mem_tb_top;
   localparam int NP = 4, DW = 16, DEPTH = 16, AW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [NP-1:0]         req_valid, req_ready, rsp_valid, rsp_ok, rsp_err;
   logic [NP-1:0][2:0]    req_op;
   logic [NP-1:0][AW-1:0] req_addr_a, req_addr_b;
   logic [NP-1:0][DW-1:0] req_cmp_a, req_cmp_b, req_new_a, req_new_b;
   logic [NP-1:0][DW-1:0] rsp_old_a, rsp_old_b;

   logic          v_valid [NP];
   logic [2:0]    v_op [NP];
   logic [AW-1:0] v_a [NP], v_b [NP];
   logic [DW-1:0] v_ca [NP], v_cb [NP], v_na [NP], v_nb [NP];

   always_comb begin
      for (int p = 0; p < NP; p++) begin
         req_valid[p] = v_valid[p]; req_op[p] = v_op[p];
         req_addr_a[p] = v_a[p]; req_addr_b[p] = v_b[p];
         req_cmp_a[p] = v_ca[p]; req_cmp_b[p] = v_cb[p];
         req_new_a[p] = v_na[p]; req_new_b[p] = v_nb[p];
      end
   end

   atomic_cas_mem #(.NP(NP), .DW(DW), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr_a(req_addr_a), .req_addr_b(req_addr_b),
      .req_cmp_a(req_cmp_a), .req_cmp_b(req_cmp_b), .req_new_a(req_new_a),
      .req_new_b(req_new_b), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
      .rsp_err(rsp_err), .rsp_old_a(rsp_old_a), .rsp_old_b(rsp_old_b)
   );

   typedef struct {
      int port; logic ok; logic err; logic [DW-1:0] a; logic [DW-1:0] b;
      int cyc; string tag;
   } exp_t;

   exp_t          exq [$];
   int            acc_log [$];
   logic [DW-1:0] mm [DEPTH];
   int            n_tests = 0, n_fail = 0, cyc = 0;
   bit            done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit cond, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // reference behaviour taken from the requirements
   task automatic model(input logic [2:0] op, input int a, input int b,
                        input logic [DW-1:0] ca, cb, na, nb,
                        output logic ok, output logic err,
                        output logic [DW-1:0] oa, output logic [DW-1:0] ob);
      int nb_ix;
      nb_ix = a + 1;
      ok = 0; err = 0; oa = mm[a]; ob = '0;
      case (op)
         3'd0: ok = 1;
         3'd1: begin ok = 1; mm[a] = na; end
         3'd2: if (mm[a] == ca) begin ok = 1; mm[a] = na; end
         3'd3, 3'd5: begin
            if (a % 2 == 1) err = 1;
            else begin
               ob = mm[nb_ix];
               ok = (mm[a] == ca) && (op == 3'd5 || mm[nb_ix] == cb);
               if (ok) begin mm[a] = na; mm[nb_ix] = nb; end
            end
         end
         3'd4: begin
            ob = mm[b];
            ok = (mm[a] == ca) && (mm[b] == cb);
            if (ok) begin mm[a] = na; mm[b] = nb; end
         end
         default: err = 1;
      endcase
      if (err) begin oa = '0; ob = '0; end
   endtask

   task automatic do_op(input int p, input logic [2:0] op, input int a, input int b,
                        input logic [DW-1:0] ca, cb, na, nb, input string tag);
      exp_t e;
      @(negedge clk);
      v_op[p] = op; v_a[p] = AW'(a); v_b[p] = AW'(b);
      v_ca[p] = ca; v_cb[p] = cb; v_na[p] = na; v_nb[p] = nb;
      v_valid[p] = 1'b1;
      #1;
      while (!req_ready[p]) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      v_valid[p] = 1'b0;
      acc_log.push_back(p);
      e.port = p; e.cyc = cyc; e.tag = tag;
      model(op, a, b, ca, cb, na, nb, e.ok, e.err, e.a, e.b);
      exq.push_back(e);
   endtask

   // monitor: pops expected responses, R9 latency and port routing
   always @(negedge clk) begin
      if (rst_n) begin
         for (int p = 0; p < NP; p++) begin
            if (rsp_valid[p]) begin
               if (exq.size() == 0) begin
                  chk(0, "R9", "unexpected response port", 64'(p), 64'hFFFF);
               end else begin
                  exp_t e;
                  e = exq.pop_front();
                  chk(e.port == p, "R9", "response port", 64'(p), 64'(e.port));
                  chk(e.cyc + 1 == cyc, "R9", "response cycle", 64'(cyc), 64'(e.cyc + 1));
                  chk({rsp_ok[p], rsp_err[p], rsp_old_a[p], rsp_old_b[p]} ==
                      {e.ok, e.err, e.a, e.b}, e.tag, "ok/err/old_a/old_b",
                      64'({rsp_ok[p], rsp_err[p], rsp_old_a[p], rsp_old_b[p]}),
                      64'({e.ok, e.err, e.a, e.b}));
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < NP; p++) begin
         v_valid[p] = 0; v_op[p] = 0; v_a[p] = 0; v_b[p] = 0;
         v_ca[p] = 0; v_cb[p] = 0; v_na[p] = 0; v_nb[p] = 0;
      end
      for (int i = 0; i < DEPTH; i++) mm[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid == '0 && req_ready == '0, "R1", "idle outputs after reset",
          64'({rsp_valid, req_ready}), 64'h0);
      do_op(0, 3'd0, 0, 0, 0, 0, 0, 0, "R1");
      do_op(1, 3'd0, 15, 0, 0, 0, 0, 0, "R1");
      // R2 plain access
      do_op(2, 3'd1, 3, 0, 0, 0, 16'h1111, 0, "R2");
      do_op(2, 3'd1, 3, 0, 0, 0, 16'h2222, 0, "R2");
      do_op(3, 3'd0, 3, 0, 0, 0, 0, 0, "R2");
      // R3 single compare
      do_op(0, 3'd2, 3, 0, 16'h2222, 0, 16'h3333, 0, "R3");
      do_op(0, 3'd2, 3, 0, 16'h2222, 0, 16'h4444, 0, "R3");
      do_op(1, 3'd0, 3, 0, 0, 0, 0, 0, "R3");
      // R4 double-wide pair
      do_op(0, 3'd1, 4, 0, 0, 0, 16'hA0A0, 0, "R4");
      do_op(0, 3'd1, 5, 0, 0, 0, 16'hB0B0, 0, "R4");
      do_op(1, 3'd3, 4, 0, 16'hA0A0, 16'hB0B0, 16'hC0C0, 16'hD0D0, "R4");
      do_op(2, 3'd3, 4, 0, 16'hC0C0, 16'h0000, 16'h1234, 16'h5678, "R4");
      do_op(2, 3'd3, 4, 0, 16'h0000, 16'hD0D0, 16'h1234, 16'h5678, "R4");
      do_op(3, 3'd0, 4, 0, 0, 0, 0, 0, "R4");
      do_op(3, 3'd0, 5, 0, 0, 0, 0, 0, "R4");
      // R5 two independent words
      do_op(0, 3'd1, 9, 0, 0, 0, 16'h0909, 0, "R5");
      do_op(1, 3'd4, 1, 9, 16'h0000, 16'h0909, 16'h0111, 16'h0999, "R5");
      do_op(1, 3'd4, 1, 9, 16'h0111, 16'h0000, 16'hEEEE, 16'hFFFF, "R5");
      do_op(2, 3'd0, 1, 0, 0, 0, 0, 0, "R5");
      do_op(2, 3'd0, 9, 0, 0, 0, 0, 0, "R5");
      do_op(3, 3'd4, 7, 7, 16'h0000, 16'h0000, 16'h7A7A, 16'h7B7B, "R5");
      do_op(3, 3'd0, 7, 0, 0, 0, 0, 0, "R5");
      // R6 compare one, write two (cmp_b deliberately wrong)
      do_op(0, 3'd1, 11, 0, 0, 0, 16'h5555, 0, "R6");
      do_op(1, 3'd5, 10, 0, 16'h0000, 16'hDEAD, 16'h1010, 16'h1111, "R6");
      do_op(1, 3'd5, 10, 0, 16'h0000, 16'h1111, 16'h2020, 16'h2121, "R6");
      do_op(2, 3'd0, 10, 0, 0, 0, 0, 0, "R6");
      do_op(2, 3'd0, 11, 0, 0, 0, 0, 0, "R6");
      // R7 errors leave memory untouched
      do_op(0, 3'd3, 5, 0, 16'hB0B0, 16'h0, 16'h9999, 16'h9999, "R7");
      do_op(0, 3'd5, 11, 0, 16'h1111, 16'h0, 16'h9999, 16'h9999, "R7");
      do_op(0, 3'd7, 3, 0, 16'h3333, 16'h0, 16'h9999, 16'h9999, "R7");
      do_op(0, 3'd6, 3, 0, 16'h3333, 16'h0, 16'h9999, 16'h9999, "R7");
      do_op(1, 3'd0, 3, 0, 0, 0, 0, 0, "R7");
      do_op(1, 3'd0, 11, 0, 0, 0, 0, 0, "R7");
      do_op(1, 3'd0, 12, 0, 0, 0, 0, 0, "R7");
      // R8 / R10: rotation and contention on one word
      do_op(0, 3'd0, 2, 0, 0, 0, 0, 0, "R8");
      acc_log.delete();
      fork
         do_op(0, 3'd2, 2, 0, 16'h0, 0, 16'h00A0, 0, "R10");
         do_op(1, 3'd2, 2, 0, 16'h0, 0, 16'h00A1, 0, "R10");
         do_op(2, 3'd2, 2, 0, 16'h0, 0, 16'h00A2, 0, "R10");
         do_op(3, 3'd2, 2, 0, 16'h0, 0, 16'h00A3, 0, "R10");
      join
      chk(acc_log.size() == 4 && acc_log[0] == 1 && acc_log[1] == 2 &&
          acc_log[2] == 3 && acc_log[3] == 0, "R8", "grant order 1,2,3,0",
          64'({acc_log[0][3:0], acc_log[1][3:0], acc_log[2][3:0], acc_log[3][3:0]}),
          64'h1230);
      acc_log.delete();
      fork
         do_op(3, 3'd1, 6, 0, 0, 0, 16'h0006, 0, "R8");
         do_op(2, 3'd2, 6, 0, 16'h0006, 0, 16'h0066, 0, "R10");
      join
      chk(acc_log.size() == 2 && acc_log[0] == 2 && acc_log[1] == 3, "R8",
          "grant order 2,3", 64'({acc_log[0][3:0], acc_log[1][3:0]}), 64'h23);
      do_op(0, 3'd0, 2, 0, 0, 0, 0, 0, "R10");
      do_op(0, 3'd0, 6, 0, 0, 0, 0, 0, "R10");
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk(exq.size() == 0, "R9", "outstanding responses", 64'(exq.size()), 64'h0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule